// File: doc/BRIEF.md
# Processor Status Flags and Condition Evaluator

This block holds the eight-bit status word of a small processor core and answers whether a conditional branch or skip would be taken against it. The execute stage writes arithmetic and logic results into the word through a value and a per-bit write mask. Each bit is updated only where the mask is 1. Separate single-bit commands force one flag, chosen by a three-bit index, to 1 or to 0. These commands serve the dedicated set-flag and clear-flag operations for all eight flags.

The condition side is purely combinational on the current register contents. The fetch or branch unit presents a four-bit condition code, plus a bit index for the generic bit-test codes. The block returns a single taken flag in the same cycle. Unsigned comparisons are decoded from the carry flag and signed comparisons from the sign flag, so the caller chooses the flavour by choosing the code. Program-counter arithmetic, instruction fetch and interrupt entry are handled elsewhere.

Top module: `status_flags_unit`

## Requirements
- R1: A synchronous active-low reset clears all eight status bits to 0x00, so the interrupt-enable bit is off after reset.
- R2: The bit positions are fixed: bit 7 interrupt enable, bit 6 bit-copy, bit 5 half carry, bit 4 sign (S), bit 3 overflow (V), bit 2 negative, bit 1 zero (Z), bit 0 carry (C).
- R3: With `upd_en` high on a clock edge, each bit whose `upd_mask` bit is 1 takes the matching `upd_value` bit, and each bit whose mask bit is 0 keeps its value.
- R4: With `flag_cmd_en` high, the bit selected by `flag_cmd_idx` (0 to 7) becomes `flag_cmd_set` (1 sets, 0 clears) on the clock edge, and the other seven bits are unchanged.
- R5: When a flag command and a masked update arrive in the same cycle, the command decides the bit it names, and the update still applies to every other masked bit.
- R6: With neither `upd_en` nor `flag_cmd_en` high, the register keeps its value across the clock edge.
- R7: Condition code 0 (equal) is taken when Z = 1, and code 1 (not equal) is taken when Z = 0.
- R8: Code 2 (carry set / unsigned lower) is taken when C = 1, and code 3 (carry clear / unsigned same-or-higher) is taken when C = 0.
- R9: Code 4 (signed less-than) is taken when S = 1, and code 5 (signed greater-or-equal) is taken when S = 0.
- R10: Code 6 (overflow set) is taken when V = 1, and code 7 (overflow clear) is taken when V = 0.
- R11: Code 8 is taken when the status bit selected by `cond_idx` is 1, and code 9 is taken when that bit is 0.
- R12: Codes 10 to 15 are never taken.
- R13: `cond_taken` reflects the register value shown on `flags` in the same cycle, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| upd_en | input | 1 | Apply masked flag update from the execute stage |
| upd_mask | input | 8 | Per-bit write mask for the update |
| upd_value | input | 8 | New flag values for masked bits |
| flag_cmd_en | input | 1 | Single-bit set/clear command valid |
| flag_cmd_set | input | 1 | 1 sets the indexed bit, 0 clears it |
| flag_cmd_idx | input | 3 | Index of the bit to set or clear |
| cond_code | input | 4 | Condition to evaluate |
| cond_idx | input | 3 | Bit index for the bit-test conditions |
| flags | output | 8 | Current status register value |
| cond_taken | output | 1 | Selected condition holds on the current value |

## Verification
Every one of the 256 register values is loaded through a full-mask update and then queried with all sixteen codes and all eight bit indices. This sweep separates a swapped flag position from a wrong polarity and from a wrong bit-index mux, and it shows that the reserved codes stay silent. Masked updates are driven with mask patterns that keep alternating, sparse and dense bit sets, which exposes a mask applied to the wrong bits or inverted. Flag commands are applied on every index in both directions, each alone and together with a conflicting masked update, which reveals a wrong priority between the two write paths or a command that disturbs neighbouring bits.

// File: rtl/sreg_pkg.sv
// Shared constants for the status flags unit.
// Assumes an eight-bit status word with a fixed flag layout.
package sreg_pkg;

    localparam int SR_W   = 8;
    localparam int IDX_W  = $clog2(SR_W);
    localparam int CODE_W = 4;

    // Flag positions inside the status word.
    localparam int POS_C = 0;
    localparam int POS_Z = 1;
    localparam int POS_N = 2;
    localparam int POS_V = 3;
    localparam int POS_S = 4;
    localparam int POS_H = 5;
    localparam int POS_T = 6;
    localparam int POS_I = 7;

    // Condition codes accepted by the evaluator.
    typedef enum logic [CODE_W-1:0] {
        CND_ZERO_SET  = 4'd0,
        CND_ZERO_CLR  = 4'd1,
        CND_CARRY_SET = 4'd2,
        CND_CARRY_CLR = 4'd3,
        CND_SIGN_SET  = 4'd4,
        CND_SIGN_CLR  = 4'd5,
        CND_OVF_SET   = 4'd6,
        CND_OVF_CLR   = 4'd7,
        CND_BIT_SET   = 4'd8,
        CND_BIT_CLR   = 4'd9
    } cond_e;

endpackage

// File: rtl/sreg_next.sv
// Next-state logic for the status word.
// Each bit picks, in priority order: flag command on this bit,
// masked execute-stage update, otherwise the current value.
// Assumes the command index is always in range for the width.
module sreg_next
    import sreg_pkg::*;
#(
    parameter int W     = SR_W,
    parameter int IDX_B = IDX_W
) (
    input  logic [W-1:0]     cur,
    input  logic             upd_en,
    input  logic [W-1:0]     upd_mask,
    input  logic [W-1:0]     upd_value,
    input  logic             cmd_en,
    input  logic             cmd_set,
    input  logic [IDX_B-1:0] cmd_idx,
    output logic [W-1:0]     nxt
);

    logic [W-1:0] cmd_hit;

    for (genvar g = 0; g < W; g++) begin : g_bit
        // Decode whether the single-bit command addresses this bit.
        assign cmd_hit[g] = cmd_en && (cmd_idx == IDX_B'(g));

        // Select the new value of this bit by priority.
        always_comb begin
            if (cmd_hit[g]) begin
                nxt[g] = cmd_set;
            end else if (upd_en && upd_mask[g]) begin
                nxt[g] = upd_value[g];
            end else begin
                nxt[g] = cur[g];
            end
        end
    end

endmodule

// File: rtl/sreg_store.sv
// Status word storage with synchronous active-low reset to zero.
// Assumes the next value is always valid; loads every cycle.
module sreg_store
    import sreg_pkg::*;
#(
    parameter int W = SR_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Register the status word, clearing it during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/cond_eval.sv
// Combinational branch/skip condition evaluator.
// Assumes the fixed flag layout from sreg_pkg; unknown codes give 0.
module cond_eval
    import sreg_pkg::*;
#(
    parameter int W     = SR_W,
    parameter int IDX_B = IDX_W,
    parameter int CW    = CODE_W
) (
    input  logic [W-1:0]     st,
    input  logic [CW-1:0]    code,
    input  logic [IDX_B-1:0] idx,
    output logic             taken
);

    logic sel_bit;

    // Pick the status bit addressed by the generic bit-test index.
    always_comb begin
        sel_bit = st[idx];
    end

    // Decode the condition code against the flags.
    always_comb begin
        case (cond_e'(code))
            CND_ZERO_SET:  taken =  st[POS_Z];
            CND_ZERO_CLR:  taken = !st[POS_Z];
            CND_CARRY_SET: taken =  st[POS_C];
            CND_CARRY_CLR: taken = !st[POS_C];
            CND_SIGN_SET:  taken =  st[POS_S];
            CND_SIGN_CLR:  taken = !st[POS_S];
            CND_OVF_SET:   taken =  st[POS_V];
            CND_OVF_CLR:   taken = !st[POS_V];
            CND_BIT_SET:   taken =  sel_bit;
            CND_BIT_CLR:   taken = !sel_bit;
            default:       taken = 1'b0;
        endcase
    end

endmodule

// File: rtl/status_flags_unit.sv
// Top of the status flags unit: holds the processor status word,
// merges masked execute-stage updates with single-bit set/clear
// commands (command wins on its bit), and evaluates branch and
// skip conditions on the current value.
// Assumes all inputs are synchronous to clk.
module status_flags_unit
    import sreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic [SR_W-1:0]   upd_mask,
    input  logic [SR_W-1:0]   upd_value,
    input  logic              flag_cmd_en,
    input  logic              flag_cmd_set,
    input  logic [IDX_W-1:0]  flag_cmd_idx,
    input  logic [CODE_W-1:0] cond_code,
    input  logic [IDX_W-1:0]  cond_idx,
    output logic [SR_W-1:0]   flags,
    output logic              cond_taken
);

    logic [SR_W-1:0] sr_q;
    logic [SR_W-1:0] sr_d;

    sreg_next #(.W(SR_W), .IDX_B(IDX_W)) u_next (
        .cur       (sr_q),
        .upd_en    (upd_en),
        .upd_mask  (upd_mask),
        .upd_value (upd_value),
        .cmd_en    (flag_cmd_en),
        .cmd_set   (flag_cmd_set),
        .cmd_idx   (flag_cmd_idx),
        .nxt       (sr_d)
    );

    sreg_store #(.W(SR_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sr_d),
        .q     (sr_q)
    );

    cond_eval #(.W(SR_W), .IDX_B(IDX_W), .CW(CODE_W)) u_cond (
        .st    (sr_q),
        .code  (cond_code),
        .idx   (cond_idx),
        .taken (cond_taken)
    );

    // Expose the stored status word.
    assign flags = sr_q;

endmodule

// File: rtl/status_flags_unit_chk.sv
// Property checker for status_flags_unit, attached with bind.
module status_flags_unit_chk
    import sreg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              upd_en,
    input logic [SR_W-1:0]   upd_mask,
    input logic [SR_W-1:0]   upd_value,
    input logic              flag_cmd_en,
    input logic              flag_cmd_set,
    input logic [IDX_W-1:0]  flag_cmd_idx,
    input logic [CODE_W-1:0] cond_code,
    input logic [IDX_W-1:0]  cond_idx,
    input logic [SR_W-1:0]   flags,
    input logic              cond_taken
);

    // R1: a reset cycle leaves the word cleared.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (flags == '0));

    // R3: masked update alone writes masked bits, keeps the rest.
    p_masked_update_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !flag_cmd_en) |=>
            (((flags ^ $past(flags)) & ~$past(upd_mask)) == '0) &&
            (((flags ^ $past(upd_value)) & $past(upd_mask)) == '0));

    // R4, R5: the commanded bit takes the command value even with an update.
    p_cmd_bit_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flag_cmd_en |=> (flags[$past(flag_cmd_idx)] == $past(flag_cmd_set)));

    // R6: no write request keeps the word.
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_en && !flag_cmd_en) |=> $stable(flags));

    // R7: equal condition follows the zero flag.
    p_eq_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_code == 4'd0) |-> (cond_taken == flags[1]));

    // R9: signed less-than follows the sign flag.
    p_lt_sign_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_code == 4'd4) |-> (cond_taken == flags[4]));

    // R11: bit-set test follows the indexed bit.
    p_bit_test_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_code == 4'd8) |-> (cond_taken == flags[cond_idx]));

    // R12: reserved codes never report taken.
    p_reserved_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_code >= 4'd10) |-> !cond_taken);

endmodule

bind status_flags_unit status_flags_unit_chk u_chk (.*);

// File: tb/sim_status_flags_unit.sv
module sim_status_flags_unit;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       upd_en = 1'b0;
    logic [7:0] upd_mask = '0;
    logic [7:0] upd_value = '0;
    logic       flag_cmd_en = 1'b0;
    logic       flag_cmd_set = 1'b0;
    logic [2:0] flag_cmd_idx = '0;
    logic [3:0] cond_code = '0;
    logic [2:0] cond_idx = '0;
    logic [7:0] flags;
    logic       cond_taken;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    status_flags_unit u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .upd_en       (upd_en),
        .upd_mask     (upd_mask),
        .upd_value    (upd_value),
        .flag_cmd_en  (flag_cmd_en),
        .flag_cmd_set (flag_cmd_set),
        .flag_cmd_idx (flag_cmd_idx),
        .cond_code    (cond_code),
        .cond_idx     (cond_idx),
        .flags        (flags),
        .cond_taken   (cond_taken)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Expected condition result, from the requirement text.
    function automatic logic exp_taken(input logic [7:0] st, input int code, input int idx);
        logic c_f, z_f, v_f, s_f;
        c_f = st[0]; z_f = st[1]; v_f = st[3]; s_f = st[4];
        case (code)
            0: return z_f;
            1: return !z_f;
            2: return c_f;
            3: return !c_f;
            4: return s_f;
            5: return !s_f;
            6: return v_f;
            7: return !v_f;
            8: return st[idx];
            9: return !st[idx];
            default: return 1'b0;
        endcase
    endfunction

    function automatic string req_of(input int code);
        case (code)
            0, 1: return "R7";
            2, 3: return "R8";
            4, 5: return "R9";
            6, 7: return "R10";
            8, 9: return "R11";
            default: return "R12";
        endcase
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    // One clock: inputs were set after a negedge; sample after the rising edge.
    task automatic step();
        @(posedge clk);
        #(CLK_PERIOD/4);
    endtask

    task automatic idle_inputs();
        @(negedge clk);
        upd_en = 1'b0;
        flag_cmd_en = 1'b0;
    endtask

    task automatic load_full(input logic [7:0] v);
        @(negedge clk);
        upd_en = 1'b1; upd_mask = 8'hFF; upd_value = v; flag_cmd_en = 1'b0;
        step();
        idle_inputs();
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        while (cycles < WATCHDOG_CYCLES) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] model;
        // R1: reset from a non-zero word.
        rst_n = 1'b1;
        load_full(8'hA5);
        @(negedge clk); rst_n = 1'b0;
        step();
        chk("R1", flags, 8'h00);
        @(negedge clk); rst_n = 1'b1;
        cond_code = 4'd3;
        #1;
        chk("R1", {7'd0, cond_taken}, 8'h01); // carry clear after reset

        // R2, R7..R13: every word, every code, every index.
        for (int v = 0; v < 256; v++) begin
            load_full(8'(v));
            chk("R3", flags, 8'(v));
            for (int c = 0; c < 16; c++) begin
                for (int i = 0; i < 8; i++) begin
                    cond_code = 4'(c);
                    cond_idx = 3'(i);
                    #1;
                    chk(req_of(c), {7'd0, cond_taken}, {7'd0, exp_taken(8'(v), c, i)});
                end
            end
        end
        // R2: named flags sit at fixed positions (S bit 4 alone -> code 4 taken).
        load_full(8'h10);
        cond_code = 4'd4; #1;
        chk("R2", {7'd0, cond_taken}, 8'h01);
        // R13: the query follows the word with no clock.
        cond_code = 4'd0; #1;
        chk("R13", {7'd0, cond_taken}, 8'h00);

        // R3: masked updates over a spread of patterns.
        for (int k = 0; k < 64; k++) begin
            logic [7:0] base, m, val;
            base = 8'((k * 37) ^ 8'h5A);
            m = 8'((k * 73 + 11) ^ (k << 3));
            val = 8'(k * 151 + 3);
            load_full(base);
            @(negedge clk);
            upd_en = 1'b1; upd_mask = m; upd_value = val;
            step();
            chk("R3", flags, (base & ~m) | (val & m));
            idle_inputs();
        end

        // R4, R5: commands on every index, alone and against an update.
        for (int i = 0; i < 8; i++) begin
            for (int s = 0; s < 2; s++) begin
                for (int w = 0; w < 2; w++) begin
                    logic [7:0] base, val;
                    base = (s == 1) ? 8'h00 : 8'hFF;
                    if (i == 3) base = base ^ 8'h24;
                    val = ~base;
                    load_full(base);
                    @(negedge clk);
                    flag_cmd_en = 1'b1; flag_cmd_set = s[0]; flag_cmd_idx = 3'(i);
                    upd_en = w[0]; upd_mask = 8'hFF; upd_value = 8'(s == 1 ? 8'h00 : 8'hFF) ^ val ^ val;
                    model = (w == 1) ? upd_value : base;
                    model[i] = s[0];
                    step();
                    chk((w == 1) ? "R5" : "R4", flags, model);
                    idle_inputs();
                end
            end
        end
        // R5: update on other bits survives a command on one bit.
        load_full(8'h00);
        @(negedge clk);
        flag_cmd_en = 1'b1; flag_cmd_set = 1'b0; flag_cmd_idx = 3'd7;
        upd_en = 1'b1; upd_mask = 8'h81; upd_value = 8'hFF;
        step();
        chk("R5", flags, 8'h01);
        idle_inputs();

        // R6: no request keeps the word over several cycles.
        load_full(8'h3C);
        @(negedge clk);
        upd_mask = 8'hFF; upd_value = 8'h00; flag_cmd_idx = 3'd2; flag_cmd_set = 1'b0;
        for (int n = 0; n < 4; n++) begin
            step();
            chk("R6", flags, 8'h3C);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule